// File: doc/BRIEF.md
# Trap Cause Priority Arbiter

This block decides which single trap an in-order core takes at an instruction boundary. Each cycle the core may present a boundary strobe. With it come three interrupt classes (external, software, timer), each with a pending bit and an enable bit, a global interrupt enable, and an exception flag with a 4-bit cause code for the instruction in the commit slot. One cycle after a boundary with at least one eligible event, the block pulses a take strobe. With the strobe it gives an interrupt/exception flag, a 4-bit cause code, and a flush request when the committing instruction carried an exception.

Interrupts outrank exceptions. When an interrupt wins over a simultaneous exception, the exception is not recorded. The faulting instruction is flushed, and it raises the exception again when it is refetched after the handler returns. A fixed order (external, software, timer) resolves ties among interrupts. Each class also has an age counter, so a class that keeps losing is promoted and cannot be starved.

The boundary strobe is a one-way valid signal with no ready. The core must accept each take pulse in the cycle it appears, and the block never applies back-pressure. All other pins are plain level signals.

Top module: `trap_arbiter`

## Requirements
- R1: After reset, `trap_take`, `trap_is_irq`, `trap_code` and `trap_flush` are all 0.
- R2: An interrupt class is eligible only when its pending bit, its enable bit and `glb_ie` are all 1. Class index 0 is external, 1 is software and 2 is timer, in both `irq_pend` and `irq_en`. When `glb_ie` is 0, only the exception can be selected.
- R3: When no class is promoted, the priority order is external, then software, then timer, then the synchronous exception.
- R4: When an interrupt wins, `trap_is_irq` is 1 and `trap_code` is 11 for external, 3 for software and 7 for timer.
- R5: When the exception wins, `trap_is_irq` is 0 and `trap_code` equals the `exc_code` that came with that boundary.
- R6: `trap_take` is 1 for exactly one cycle, and only in the cycle after a cycle with `bnd_valid` = 1 in which some event was eligible. With `bnd_valid` = 0, no input produces a take.
- R7: `trap_flush` is 1 exactly when `trap_take` is 1 and `exc_valid` was 1 at that boundary, whichever event won. It is never 1 without `trap_take`. No exception state is kept after an interrupt wins.
- R8: An eligible class that loses at STARVE_LIMIT (default 4) consecutive boundaries, while staying eligible, wins the next boundary ahead of the fixed order. Its age is cleared when it wins, or at any boundary where it is not eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bnd_valid | input | 1 | Instruction boundary strobe |
| irq_pend | input | 3 | Pending bits [0]=external [1]=software [2]=timer |
| irq_en | input | 3 | Per-class enable bits, same order |
| glb_ie | input | 1 | Global interrupt enable |
| exc_valid | input | 1 | Commit-slot instruction raised an exception |
| exc_code | input | 4 | Exception cause code |
| trap_take | output | 1 | Take-trap pulse |
| trap_is_irq | output | 1 | 1 = interrupt, 0 = exception |
| trap_code | output | 4 | Cause code of the taken trap |
| trap_flush | output | 1 | Flush the committing instruction |

## Verification
Every result is registered once, so the outputs for a boundary appear exactly one clock after the boundary edge. The bench drives inputs on the falling edge and samples the outputs on the next falling edge. It sweeps all 256 combinations of pending, enable, global enable and exception valid. After each combination it sends a boundary with `glb_ie` = 0, which clears every age counter, so each expected value comes from the plain fixed-priority rule. Separate sequences with interrupts held pending count boundaries one by one, and check that the promoted class wins on the fifth.

// File: rtl/trap_arb_pkg.sv
package trap_arb_pkg;
  localparam int NCLS  = 3;
  localparam int CW    = 4;
  typedef logic [CW-1:0] code_t;

  function automatic code_t cls_code(input int idx);
    case (idx)
      0:       return code_t'(11);
      1:       return code_t'(3);
      default: return code_t'(7);
    endcase
  endfunction
endpackage

// File: rtl/trap_req_qual.sv
module trap_req_qual #(
  parameter int N = 3
) (
  input  logic [N-1:0] pend,
  input  logic [N-1:0] en,
  input  logic         gie,
  output logic [N-1:0] elig
);
  for (genvar g = 0; g < N; g++) begin : g_q
    assign elig[g] = pend[g] & en[g] & gie;
  end
endmodule

// File: rtl/trap_starve_guard.sv
module trap_starve_guard #(
  parameter int N     = 3,
  parameter int LIMIT = 4,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bnd,
  input  logic [N-1:0] elig,
  input  logic [N-1:0] grant,
  output logic [N-1:0] urgent
);
  for (genvar g = 0; g < N; g++) begin : g_age
    logic [CNT_W-1:0] age_q;
    always_ff @(posedge clk) begin
      if (!rst_n) age_q <= '0;
      else if (bnd) begin
        if (!elig[g] || grant[g]) age_q <= '0;
        else if (age_q < CNT_W'(LIMIT)) age_q <= age_q + 1'b1;
      end
    end
    assign urgent[g] = elig[g] && (age_q >= CNT_W'(LIMIT));

    // R8
    age_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      age_q <= CNT_W'(LIMIT));
  end
endmodule

// File: rtl/trap_pick.sv
module trap_pick
  import trap_arb_pkg::*;
#(
  parameter int N = 3
) (
  input  logic [N-1:0] elig,
  input  logic [N-1:0] urgent,
  input  logic         exc_valid,
  input  code_t        exc_code,
  output logic [N-1:0] grant,
  output logic         any,
  output logic         is_irq,
  output code_t        code
);
  logic found;

  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!found && urgent[i]) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
    for (int i = 0; i < N; i++) begin
      if (!found && elig[i]) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    code = exc_code;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) code = cls_code(i);
    end
    is_irq = found;
    any    = found | exc_valid;
  end
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_arb_pkg::*;
#(
  parameter int STARVE_LIMIT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bnd_valid,
  input  logic [NCLS-1:0] irq_pend,
  input  logic [NCLS-1:0] irq_en,
  input  logic            glb_ie,
  input  logic            exc_valid,
  input  logic [CW-1:0]   exc_code,
  output logic            trap_take,
  output logic            trap_is_irq,
  output logic [CW-1:0]   trap_code,
  output logic            trap_flush
);
  logic [NCLS-1:0] elig, urgent, grant, grant_b;
  logic            any, sel_irq;
  code_t           sel_code;

  trap_req_qual #(.N(NCLS)) qual_i (
    .pend(irq_pend), .en(irq_en), .gie(glb_ie), .elig(elig)
  );

  assign grant_b = grant & {NCLS{bnd_valid}};

  trap_starve_guard #(.N(NCLS), .LIMIT(STARVE_LIMIT)) guard_i (
    .clk(clk), .rst_n(rst_n), .bnd(bnd_valid),
    .elig(elig), .grant(grant_b), .urgent(urgent)
  );

  trap_pick #(.N(NCLS)) pick_i (
    .elig(elig), .urgent(urgent), .exc_valid(exc_valid), .exc_code(exc_code),
    .grant(grant), .any(any), .is_irq(sel_irq), .code(sel_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_take   <= 1'b0;
      trap_is_irq <= 1'b0;
      trap_code   <= '0;
      trap_flush  <= 1'b0;
    end else if (bnd_valid && any) begin
      trap_take   <= 1'b1;
      trap_is_irq <= sel_irq;
      trap_code   <= sel_code;
      trap_flush  <= exc_valid;
    end else begin
      trap_take   <= 1'b0;
      trap_is_irq <= 1'b0;
      trap_code   <= '0;
      trap_flush  <= 1'b0;
    end
  end

  // R6
  take_needs_bnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |-> $past(bnd_valid));
  // R2
  irq_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take && trap_is_irq) |-> $past(glb_ie));
  // R4
  irq_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take && trap_is_irq) |->
      (trap_code == 4'd11 || trap_code == 4'd3 || trap_code == 4'd7));
  // R5
  exc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take && !trap_is_irq) |-> ($past(exc_valid) && trap_code == $past(exc_code)));
  // R7
  flush_with_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_flush |-> trap_take);
  // R3
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

// File: tb/trap_arbiter_tb_top.sv
module trap_arbiter_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bnd_valid = 1'b0, glb_ie = 1'b0, exc_valid = 1'b0;
  logic [2:0] irq_pend = '0, irq_en = '0;
  logic [3:0] exc_code = '0;
  logic trap_take, trap_is_irq, trap_flush;
  logic [3:0] trap_code;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  trap_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .bnd_valid(bnd_valid), .irq_pend(irq_pend),
    .irq_en(irq_en), .glb_ie(glb_ie), .exc_valid(exc_valid), .exc_code(exc_code),
    .trap_take(trap_take), .trap_is_irq(trap_is_irq), .trap_code(trap_code),
    .trap_flush(trap_flush)
  );

  task automatic check(string req, logic [6:0] act, logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act take/irq/code/flush=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic drive(logic b, logic [2:0] p, logic [2:0] e, logic g, logic xv, logic [3:0] xc);
    bnd_valid = b; irq_pend = p; irq_en = e; glb_ie = g; exc_valid = xv; exc_code = xc;
    @(negedge clk);
  endtask

  function automatic logic [6:0] ref_out(logic b, logic [2:0] p, logic [2:0] e, logic g,
                                         logic xv, logic [3:0] xc);
    logic [2:0] el = p & e & {3{g}};
    if (!b) return 7'b0;
    if (el[0]) return {1'b1, 1'b1, 4'd11, xv};
    if (el[1]) return {1'b1, 1'b1, 4'd3, xv};
    if (el[2]) return {1'b1, 1'b1, 4'd7, xv};
    if (xv)    return {1'b1, 1'b0, xc, 1'b1};
    return 7'b0;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1", {trap_take, trap_is_irq, trap_code, trap_flush}, 7'b0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < 256; v++) begin
      logic [3:0] xc = v[3:0] ^ 4'h5;
      drive(1'b1, v[2:0], v[5:3], v[6], v[7], xc);
      // R2 R3 R4 R5 R7
      check("R2/R3/R4/R5/R7", {trap_take, trap_is_irq, trap_code, trap_flush},
            ref_out(1'b1, v[2:0], v[5:3], v[6], v[7], xc));
      drive(1'b1, 3'b111, 3'b111, 1'b0, 1'b0, 4'h0);
      check("R2", {trap_take, trap_is_irq, trap_code, trap_flush}, 7'b0);
    end
    // R6: no boundary, requests present
    drive(1'b0, 3'b111, 3'b111, 1'b1, 1'b1, 4'h2);
    check("R6", {trap_take, trap_is_irq, trap_code, trap_flush}, 7'b0);
    // R6: single-cycle pulse
    drive(1'b1, 3'b000, 3'b000, 1'b0, 1'b1, 4'h6);
    check("R6", {trap_take, trap_is_irq, trap_code, trap_flush}, {1'b1, 1'b0, 4'h6, 1'b1});
    drive(1'b0, 3'b000, 3'b000, 1'b0, 1'b1, 4'h6);
    check("R6", {trap_take, trap_is_irq, trap_code, trap_flush}, 7'b0);
    // R8: external and timer held; timer promoted on 5th boundary
    for (int k = 1; k <= 6; k++) begin
      drive(1'b1, 3'b101, 3'b111, 1'b1, 1'b0, 4'h0);
      check("R8", {trap_take, trap_is_irq, trap_code, trap_flush},
            (k == 5) ? {1'b1, 1'b1, 4'd7, 1'b0} : {1'b1, 1'b1, 4'd11, 1'b0});
    end
    // R8: gaps without boundary keep age; software starved by external
    drive(1'b1, 3'b000, 3'b000, 1'b0, 1'b0, 4'h0);
    for (int k = 1; k <= 5; k++) begin
      drive(1'b1, 3'b011, 3'b111, 1'b1, 1'b1, 4'h9);
      check("R8", {trap_take, trap_is_irq, trap_code, trap_flush},
            (k == 5) ? {1'b1, 1'b1, 4'd3, 1'b1} : {1'b1, 1'b1, 4'd11, 1'b1});
      drive(1'b0, 3'b011, 3'b111, 1'b1, 1'b1, 4'h9);
    end
    // R8: a non-eligible boundary clears age
    for (int k = 1; k <= 3; k++) drive(1'b1, 3'b101, 3'b111, 1'b1, 1'b0, 4'h0);
    drive(1'b1, 3'b001, 3'b111, 1'b1, 1'b0, 4'h0);
    for (int k = 1; k <= 2; k++) begin
      drive(1'b1, 3'b101, 3'b111, 1'b1, 1'b0, 4'h0);
      check("R8", {trap_take, trap_is_irq, trap_code, trap_flush}, {1'b1, 1'b1, 4'd11, 1'b0});
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=hung exp=finished");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule